// File: doc/BRIEF.md
# Hash Command Sequence Error Checker

This block watches the command stream that software issues to a sponge-based hash and MAC engine. It keeps its own copy of the engine's command state and checks every command against that state. On the start of a message it also checks the configuration that goes with it: the hash mode and strength pair, the MAC key prefix and whether an entropy seed has been delivered.

When a check fails, the block raises a one-cycle error pulse with a two-bit cause code. Where the failure must not reach the engine, it also asserts a blocking flag in the same cycle as the offending command. While that flag is high, the tracked state stays where it is. An escalation input sends the tracker into a terminal state. That state can only be left by reset.

Top module: `hash_cmd_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `state_o` is Idle (0), `err_valid_o` is 0 and `block_o` is 0 with the None command applied. The state codes are Idle=0, Feed=1, Processing=2, Absorbed=3, Squeezing=4 and Terminal=5.
- R2: In Idle, the Start command (code 1) moves the state to Feed at the next edge, but only while `app_busy_i` is low. With `app_busy_i` high the state stays Idle and no error is raised.
- R3: In Feed, the Process command (code 2) moves the state to Processing. Processing moves to Absorbed only when `absorbed_i` equals exactly 4'b0110; any other absorbed value leaves the state in Processing.
- R4: In Absorbed, Run (code 3) moves to Squeezing and Done (code 4) moves to Idle. Squeezing returns to Absorbed when `perm_done_i` is high.
- R5: The legal commands per state are: Idle accepts None (0) and Start; Feed accepts None and Process; Absorbed accepts None, Run and Done; Processing and Squeezing accept only None. Codes 5 to 7 are never legal. Any other command raises a sequence error (code 0), raises `block_o` in the same cycle and holds the state.
- R6: On a Start that would leave Idle, the mode/strength pair is checked. The mode codes are SHA3=0, SHAKE=1, cSHAKE=2; the strength codes are 128=0, 224=1, 256=2, 384=3, 512=4. SHA3 is legal with 224, 256, 384 or 512, and SHAKE and cSHAKE are legal with 128 or 256. Any other pair raises error code 1 and blocks, unless `allow_unsup_i` is high; in that case the error is still reported but the move to Feed proceeds.
- R7: On such a Start with `mac_en_i` high, a `prefix_i` other than bytes 01 20 4B 4D 41 43 raises error code 2 without blocking. The first byte sits in bits [7:0].
- R8: On such a Start with `mac_en_i` high and no entropy seed held, error code 3 is raised and the command is blocked. A seed is recorded by a `seed_pulse_i` that arrives in Idle; a pulse in any other state is ignored. `err_ack_i` clears the seed.
- R9: When several errors occur at once, the reported code follows this order: sequence (0), then mode/strength (1), then prefix (2), then entropy (3).
- R10: `escalate_i` high forces Terminal at the next edge from any state. Terminal ignores all commands and raises no errors.
- R11: `err_valid_o` and `err_code_o` appear one cycle after the offending command, and the pulse lasts one cycle when the command is not repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Software command code |
| mode_i | input | 2 | Hash mode |
| strength_i | input | 3 | Security strength |
| mac_en_i | input | 1 | MAC mode enabled |
| prefix_i | input | 48 | Six-byte function-name prefix |
| allow_unsup_i | input | 1 | Lets unsupported mode/strength pairs proceed |
| seed_pulse_i | input | 1 | Entropy seed delivered |
| err_ack_i | input | 1 | Error acknowledge; clears the seed |
| app_busy_i | input | 1 | An application interface holds the engine |
| absorbed_i | input | 4 | Multi-bit absorbed indication |
| perm_done_i | input | 1 | Permutation finished |
| escalate_i | input | 1 | Escalation request |
| err_valid_o | output | 1 | Error pulse |
| err_code_o | output | 2 | Error cause |
| block_o | output | 1 | Current command is blocked |
| state_o | output | 3 | Tracked command state |

## Verification
Every state is reached by a legal path and then hit with each of the eight command codes. This separates the legal sets for each state and confirms that the state holds on a blocked command. All 32 mode/strength pairs are applied at Start, both with and without the override, which tells blocking apart from mere reporting.

The prefix is corrupted one byte at a time to show that every byte is compared. The seed is tested in four cases: present, absent, delivered outside Idle, and cleared by acknowledge. All sixteen absorbed values are swept to show that only the exact code advances Processing. Combined faults check the cause priority, and escalation is applied from every state.

// File: rtl/hash_cmd_checker.sv
module hash_cmd_checker #(
  parameter int CMD_W    = 3,
  parameter int MODE_W   = 2,
  parameter int STR_W    = 3,
  parameter int ABS_W    = 4,
  parameter int PREFIX_W = 48,
  parameter logic [ABS_W-1:0]    ABS_TRUE   = 4'b0110,
  parameter logic [PREFIX_W-1:0] MAC_PREFIX = 48'h43414D4B2001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [STR_W-1:0]    strength_i,
  input  logic                mac_en_i,
  input  logic [PREFIX_W-1:0] prefix_i,
  input  logic                allow_unsup_i,
  input  logic                seed_pulse_i,
  input  logic                err_ack_i,
  input  logic                app_busy_i,
  input  logic [ABS_W-1:0]    absorbed_i,
  input  logic                perm_done_i,
  input  logic                escalate_i,
  output logic                err_valid_o,
  output logic [1:0]          err_code_o,
  output logic                block_o,
  output logic [2:0]          state_o
);

  localparam logic [CMD_W-1:0] C_NONE  = CMD_W'(0);
  localparam logic [CMD_W-1:0] C_START = CMD_W'(1);
  localparam logic [CMD_W-1:0] C_PROC  = CMD_W'(2);
  localparam logic [CMD_W-1:0] C_RUN   = CMD_W'(3);
  localparam logic [CMD_W-1:0] C_DONE  = CMD_W'(4);

  localparam logic [MODE_W-1:0] M_SHA3   = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_SHAKE  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_CSHAKE = MODE_W'(2);

  localparam logic [STR_W-1:0] L128 = STR_W'(0);
  localparam logic [STR_W-1:0] L224 = STR_W'(1);
  localparam logic [STR_W-1:0] L256 = STR_W'(2);
  localparam logic [STR_W-1:0] L384 = STR_W'(3);
  localparam logic [STR_W-1:0] L512 = STR_W'(4);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_FEED = 3'd1;
  localparam logic [2:0] S_PROC = 3'd2;
  localparam logic [2:0] S_ABS  = 3'd3;
  localparam logic [2:0] S_SQZ  = 3'd4;
  localparam logic [2:0] S_TERM = 3'd5;

  logic [2:0] st, st_d;
  logic       seq_err, ms_err, pfx_err, ent_err, start_go, ms_ok;
  logic       seed_q;

  always_comb begin
    st_d = st;
    case (st)
      S_IDLE:  if (!app_busy_i && cmd_i == C_START) st_d = S_FEED;
      S_FEED:  if (cmd_i == C_PROC) st_d = S_PROC;
      S_PROC:  if (absorbed_i == ABS_TRUE) st_d = S_ABS;
      S_ABS: begin
        if (cmd_i == C_RUN)       st_d = S_SQZ;
        else if (cmd_i == C_DONE) st_d = S_IDLE;
      end
      S_SQZ:   if (perm_done_i) st_d = S_ABS;
      S_TERM:  st_d = S_TERM;
      default: st_d = S_TERM;
    endcase
  end

  always_comb begin
    case (st)
      S_IDLE:        seq_err = !(cmd_i inside {C_NONE, C_START});
      S_FEED:        seq_err = !(cmd_i inside {C_NONE, C_PROC});
      S_PROC, S_SQZ: seq_err = cmd_i != C_NONE;
      S_ABS:         seq_err = !(cmd_i inside {C_NONE, C_RUN, C_DONE});
      default:       seq_err = 1'b0;
    endcase
  end

  assign start_go = (st == S_IDLE) && (st_d == S_FEED);
  assign ms_ok    = ((mode_i == M_SHA3) && (strength_i inside {L224, L256, L384, L512}))
                 || (((mode_i == M_SHAKE) || (mode_i == M_CSHAKE)) && (strength_i inside {L128, L256}));
  assign ms_err   = start_go && !ms_ok;
  assign pfx_err  = start_go && mac_en_i && (prefix_i != MAC_PREFIX);
  assign ent_err  = start_go && mac_en_i && !seed_q;
  assign block_o  = seq_err || (ms_err && !allow_unsup_i) || ent_err;
  assign state_o  = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          st <= S_IDLE;
    else if (escalate_i) st <= S_TERM;
    else if (!block_o)   st <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              seed_q <= 1'b0;
    else if (err_ack_i)                      seed_q <= 1'b0;
    else if (seed_pulse_i && st == S_IDLE)   seed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid_o <= 1'b0;
      err_code_o  <= 2'd0;
    end else begin
      err_valid_o <= seq_err || ms_err || pfx_err || ent_err;
      if (seq_err)      err_code_o <= 2'd0;
      else if (ms_err)  err_code_o <= 2'd1;
      else if (pfx_err) err_code_o <= 2'd2;
      else if (ent_err) err_code_o <= 2'd3;
    end
  end

  a_r5_block_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    block_o && !escalate_i |=> $stable(state_o));
  a_r11_block_reports: assert property (@(posedge clk) disable iff (!rst_n)
    block_o |=> err_valid_o);
  a_r10_escalate_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    escalate_i |=> state_o == S_TERM);
  a_r10_terminal_absorbing: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_TERM |=> state_o == S_TERM);
  a_r3_absorb_strict: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_PROC && absorbed_i != ABS_TRUE && !escalate_i |=> state_o == S_PROC);
  a_r10_terminal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_TERM |-> !block_o);

endmodule

// File: tb/hash_cmd_checker_test.sv
`timescale 1ns/100ps
module hash_cmd_checker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd_i;
  logic [1:0]  mode_i;
  logic [2:0]  strength_i;
  logic        mac_en_i;
  logic [47:0] prefix_i;
  logic        allow_unsup_i, seed_pulse_i, err_ack_i, app_busy_i;
  logic [3:0]  absorbed_i;
  logic        perm_done_i, escalate_i;
  logic        err_valid_o;
  logic [1:0]  err_code_o;
  logic        block_o;
  logic [2:0]  state_o;

  localparam logic [47:0] GOOD_PFX = 48'h43414D4B2001;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hash_cmd_checker uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .mode_i(mode_i), .strength_i(strength_i),
    .mac_en_i(mac_en_i), .prefix_i(prefix_i), .allow_unsup_i(allow_unsup_i),
    .seed_pulse_i(seed_pulse_i), .err_ack_i(err_ack_i), .app_busy_i(app_busy_i),
    .absorbed_i(absorbed_i), .perm_done_i(perm_done_i), .escalate_i(escalate_i),
    .err_valid_o(err_valid_o), .err_code_o(err_code_o), .block_o(block_o), .state_o(state_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    cmd_i = 3'd0; mode_i = 2'd0; strength_i = 3'd2; mac_en_i = 1'b0;
    prefix_i = GOOD_PFX; allow_unsup_i = 1'b0; seed_pulse_i = 1'b0;
    err_ack_i = 1'b0; app_busy_i = 1'b0; absorbed_i = 4'd0;
    perm_done_i = 1'b0; escalate_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    defaults();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic goto(input int s);
    do_reset();
    if (s == 5) begin escalate_i = 1; step(); escalate_i = 0; return; end
    if (s >= 1) begin cmd_i = 3'd1; step(); cmd_i = 3'd0; end
    if (s >= 2) begin cmd_i = 3'd2; step(); cmd_i = 3'd0; end
    if (s >= 3) begin absorbed_i = 4'b0110; step(); absorbed_i = 4'd0; end
    if (s >= 4) begin cmd_i = 3'd3; step(); cmd_i = 3'd0; end
  endtask

  function automatic bit legal(input int s, input int c);
    case (s)
      0: return c <= 1;
      1: return c == 0 || c == 2;
      2, 4: return c == 0;
      3: return c == 0 || c == 3 || c == 4;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int next_of(input int s, input int c);
    if (!legal(s, c)) return s;
    case (s)
      0: return (c == 1) ? 1 : 0;
      1: return (c == 2) ? 2 : 1;
      3: return (c == 3) ? 4 : (c == 4) ? 0 : 3;
      default: return s;
    endcase
  endfunction

  function automatic bit ms_legal(input int m, input int st);
    return (m == 0 && st >= 1 && st <= 4) || ((m == 1 || m == 2) && (st == 0 || st == 2));
  endfunction

  task automatic start_check(input string req, input int exp_state, input bit exp_err,
                             input int exp_code, input bit exp_block);
    cmd_i = 3'd1;
    #1;
    chk(block_o == exp_block, {req, " block"}, block_o, exp_block);
    @(negedge clk);
    cmd_i = 3'd0;
    chk(state_o == exp_state, {req, " state"}, state_o, exp_state);
    chk(err_valid_o == exp_err, {req, " err_valid"}, err_valid_o, exp_err);
    if (exp_err) chk(err_code_o == exp_code, {req, " code"}, err_code_o, exp_code);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    defaults();
    @(negedge clk);
    // R1 during and right after reset
    chk(state_o == 0, "R1 state in reset", state_o, 0);
    chk(err_valid_o == 0, "R1 err_valid in reset", err_valid_o, 0);
    do_reset();
    chk(state_o == 0, "R1 state after reset", state_o, 0);
    chk(block_o == 0, "R1 block after reset", block_o, 0);
    chk(err_valid_o == 0, "R1 err after reset", err_valid_o, 0);

    // R5 R2 R4 R10: every state against every command
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 8; c++) begin
        bit lg;
        int nx;
        goto(s);
        lg = legal(s, c);
        nx = next_of(s, c);
        cmd_i = 3'(c);
        #1;
        chk(block_o == !lg, "R5 block", block_o, !lg);
        @(negedge clk);
        cmd_i = 3'd0;
        chk(state_o == nx, "R5 R4 next state", state_o, nx);
        chk(err_valid_o == !lg, "R5 err_valid", err_valid_o, !lg);
        if (!lg) begin
          chk(err_code_o == 0, "R5 seq code", err_code_o, 0);
          step();
          chk(err_valid_o == 0, "R11 pulse ends", err_valid_o, 0);
        end
      end
    end

    // R4 squeezing returns on permutation done
    goto(4);
    perm_done_i = 1; step(); perm_done_i = 0;
    chk(state_o == 3, "R4 squeeze to absorbed", state_o, 3);

    // R2 application busy blocks the start silently
    goto(0);
    app_busy_i = 1;
    start_check("R2 app busy", 0, 0, 0, 0);
    app_busy_i = 0;

    // R3 only the exact absorbed code advances
    for (int a = 0; a < 16; a++) begin
      int ex;
      goto(2);
      absorbed_i = 4'(a);
      step();
      absorbed_i = 0;
      ex = (a == 6) ? 3 : 2;
      chk(state_o == ex, "R3 absorbed strict", state_o, ex);
    end

    // R6 all mode/strength pairs, with and without override
    for (int u = 0; u < 2; u++) begin
      for (int m = 0; m < 4; m++) begin
        for (int sg = 0; sg < 8; sg++) begin
          bit ok;
          goto(0);
          mode_i = 2'(m); strength_i = 3'(sg); allow_unsup_i = u[0];
          ok = ms_legal(m, sg);
          start_check("R6 mode/strength", (ok || u == 1) ? 1 : 0, !ok, 1, !ok && u == 0);
        end
      end
    end

    // R7 prefix with seed present; each byte corrupted
    goto(0);
    mac_en_i = 1; seed_pulse_i = 1; step(); seed_pulse_i = 0;
    start_check("R7 good prefix", 1, 0, 0, 0);
    for (int b = 0; b < 6; b++) begin
      goto(0);
      mac_en_i = 1; seed_pulse_i = 1; step(); seed_pulse_i = 0;
      prefix_i = GOOD_PFX ^ (48'h80 << (8 * b));
      start_check("R7 bad prefix byte", 1, 1, 2, 0);
    end

    // R8 missing seed
    goto(0);
    mac_en_i = 1;
    start_check("R8 no seed", 0, 1, 3, 1);
    // R8 seed outside Idle ignored
    goto(1);
    seed_pulse_i = 1; step(); seed_pulse_i = 0;
    cmd_i = 3'd2; step(); cmd_i = 3'd0;
    absorbed_i = 4'b0110; step(); absorbed_i = 0;
    cmd_i = 3'd4; step(); cmd_i = 3'd0;
    chk(state_o == 0, "R8 back to idle", state_o, 0);
    mac_en_i = 1;
    start_check("R8 seed outside idle", 0, 1, 3, 1);
    // R8 ack clears seed
    goto(0);
    seed_pulse_i = 1; step(); seed_pulse_i = 0;
    err_ack_i = 1; step(); err_ack_i = 0;
    mac_en_i = 1;
    start_check("R8 ack clears seed", 0, 1, 3, 1);
    // R8 MAC disabled needs no seed
    goto(0);
    start_check("R8 no mac no seed", 1, 0, 0, 0);

    // R9 priority
    goto(0);
    mac_en_i = 1; mode_i = 2'd3; prefix_i = 48'h0;
    start_check("R9 ms over prefix and entropy", 0, 1, 1, 1);
    goto(0);
    mac_en_i = 1; allow_unsup_i = 1; strength_i = 3'd7; prefix_i = 48'h0;
    start_check("R9 ms with override over entropy", 0, 1, 1, 1);
    goto(0);
    mac_en_i = 1; prefix_i = 48'h0;
    start_check("R9 prefix over entropy", 0, 1, 2, 1);

    // R10 escalation from every state, then commands ignored
    for (int s = 0; s < 5; s++) begin
      goto(s);
      escalate_i = 1; cmd_i = 3'd7; step(); escalate_i = 0; cmd_i = 3'd0;
      chk(state_o == 5, "R10 escalate", state_o, 5);
      cmd_i = 3'd1; step(); cmd_i = 3'd0;
      chk(state_o == 5 && err_valid_o == 0, "R10 terminal ignores", state_o, 5);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule